// File: doc/BRIEF.md
# Dual-Use Pin GPIO Controller

This block owns a bank of device pins. Each pin either passes a peripheral's output and output-enable straight to its pad, or acts as a general-purpose pin that drives high, drives low, or floats as an input. The low-numbered pins are dual-use. The remaining pins are GPIO-only and have no peripheral path. The pin behaviour is held as a two-bit code per pin, stored as two bit-planes.

Software changes either plane through dedicated set and clear words. A one in the written data sets or clears that pin's bit, and a zero leaves it alone, so any group of pins changes in one bus write with no read-modify-write. A separate read word returns the live pad levels after a two-flop synchronizer, whatever mode each pin is in. Pins can move between input and output at any time by rewriting their codes.

Top module: `dpg_ctrl`

## Requirements
- R1: After reset every pin is hi-Z: pad_oe and pad_out are all zero, and both mode words read zero.
- R2: The pin code is {high plane bit, low plane bit}: 00 hi-Z, 01 drive low, 10 drive high, 11 functional. The low plane reads at word 1 and the high plane at word 4, with bit i belonging to pin i.
- R3: A write to word 2 (low plane) or word 5 (high plane) sets the plane bits written as one and leaves the bits written as zero unchanged.
- R4: A write to word 3 (low plane) or word 6 (high plane) clears the plane bits written as one and leaves the bits written as zero unchanged.
- R5: Code 00 gives pad_oe=0 and pad_out=0. Code 01 gives pad_oe=1 and pad_out=0. Code 10 gives pad_oe=1 and pad_out=1. Pads follow the new code from the clock edge that takes the write.
- R6: A dual-use pin (index below N_DUAL) in code 11 copies per_out and per_oe to pad_out and pad_oe combinationally.
- R7: A GPIO-only pin (index N_DUAL and up) in code 11 behaves as hi-Z (pad_oe=0, pad_out=0), and its mode bits still read back as 11.
- R8: Word 0 returns pad_in through two flip-flop stages. A read that captures on the first or second edge after a pad change returns the old level. A read that captures on the third edge returns the new level.
- R9: Word 0 reports pad levels for pins in every mode, including driven and functional pins.
- R10: Writes to words 0, 1, 4 and 7 change no mode bit. Reads of words 2, 3, 5, 6 and 7 return zero.
- R11: bus_rdata is registered. It updates on the edge that samples bus_re and holds its value while bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | N_PINS | Write data, bit i for pin i |
| bus_rdata | output | N_PINS | Registered read data |
| per_out | input | N_DUAL | Peripheral output values for the dual-use pins |
| per_oe | input | N_DUAL | Peripheral output enables for the dual-use pins |
| pad_out | output | N_PINS | Pad output levels |
| pad_oe | output | N_PINS | Pad output enables |
| pad_in | input | N_PINS | Pad input levels |

## Verification
The bench builds the block with N_PINS=12 and N_DUAL=8, so both generate variants of the pad logic are present: eight pins with a peripheral path and four without. Code 11 can therefore be checked on dual-use and GPIO-only pins in the same run, and the full pad vectors are compared against a model of the mode planes. With twelve pins, the set and clear masks can mix pins of both kinds in a single write.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  typedef enum logic [1:0] {
    PM_HIZ  = 2'b00,
    PM_LOW  = 2'b01,
    PM_HIGH = 2'b10,
    PM_FUNC = 2'b11
  } pin_mode_e;

  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] A_PINLVL  = 3'd0;
  localparam logic [REG_AW-1:0] A_MLO     = 3'd1;
  localparam logic [REG_AW-1:0] A_MLO_SET = 3'd2;
  localparam logic [REG_AW-1:0] A_MLO_CLR = 3'd3;
  localparam logic [REG_AW-1:0] A_MHI     = 3'd4;
  localparam logic [REG_AW-1:0] A_MHI_SET = 3'd5;
  localparam logic [REG_AW-1:0] A_MHI_CLR = 3'd6;

endpackage

// File: rtl/dpg_mode_bank.sv
module dpg_mode_bank #(
  parameter int unsigned N_PINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_lo,
  input  logic              clr_lo,
  input  logic              set_hi,
  input  logic              clr_hi,
  input  logic [N_PINS-1:0] mask,
  output logic [N_PINS-1:0] mode_lo,
  output logic [N_PINS-1:0] mode_hi
);

  localparam int unsigned N_PLANES = 2;

  logic [N_PLANES-1:0][N_PINS-1:0] plane_q;
  logic [N_PLANES-1:0][N_PINS-1:0] plane_d;
  logic [N_PLANES-1:0]             set_v;
  logic [N_PLANES-1:0]             clr_v;

  assign set_v = {set_hi, set_lo};
  assign clr_v = {clr_hi, clr_lo};

  for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
    always_comb begin
      plane_d[p] = plane_q[p];
      if (set_v[p]) begin
        plane_d[p] = plane_q[p] | mask;
      end else if (clr_v[p]) begin
        plane_d[p] = plane_q[p] & ~mask;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        plane_q[p] <= '0;
      end else if (set_v[p] || clr_v[p]) begin
        plane_q[p] <= plane_d[p];
      end
    end
  end

  assign mode_lo = plane_q[0];
  assign mode_hi = plane_q[1];

endmodule

// File: rtl/dpg_pad_mux.sv
module dpg_pad_mux
  import dpg_pkg::*;
#(
  parameter int unsigned N_PINS = 12,
  parameter int unsigned N_DUAL = 8
) (
  input  logic [N_PINS-1:0] mode_lo,
  input  logic [N_PINS-1:0] mode_hi,
  input  logic [N_DUAL-1:0] per_out,
  input  logic [N_DUAL-1:0] per_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe
);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = pin_mode_e'({mode_hi[i], mode_lo[i]});

    if (i < N_DUAL) begin : g_dual
      always_comb begin
        unique case (mode)
          PM_LOW:  begin pad_oe[i] = 1'b1;      pad_out[i] = 1'b0;       end
          PM_HIGH: begin pad_oe[i] = 1'b1;      pad_out[i] = 1'b1;       end
          PM_FUNC: begin pad_oe[i] = per_oe[i]; pad_out[i] = per_out[i]; end
          default: begin pad_oe[i] = 1'b0;      pad_out[i] = 1'b0;       end
        endcase
      end
    end else begin : g_gpio_only
      always_comb begin
        unique case (mode)
          PM_LOW:  begin pad_oe[i] = 1'b1; pad_out[i] = 1'b0; end
          PM_HIGH: begin pad_oe[i] = 1'b1; pad_out[i] = 1'b1; end
          default: begin pad_oe[i] = 1'b0; pad_out[i] = 1'b0; end
        endcase
      end
    end
  end

endmodule

// File: rtl/dpg_in_sync.sv
module dpg_in_sync #(
  parameter int unsigned N_PINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] async_in,
  output logic [N_PINS-1:0] sync_out
);

  logic [N_PINS-1:0] stage1_q;
  logic [N_PINS-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/dpg_ctrl.sv
module dpg_ctrl
  import dpg_pkg::*;
#(
  parameter int unsigned N_PINS = 12,
  parameter int unsigned N_DUAL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_DUAL-1:0] per_out,
  input  logic [N_DUAL-1:0] per_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  input  logic [N_PINS-1:0] pad_in
);

  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_int;
  logic [N_PINS-1:0]     mode_lo;
  logic [N_PINS-1:0]     mode_hi;
  logic [N_PINS-1:0]     pin_lvl;
  logic [N_PINS-1:0]     rdata_d;
  logic [N_PINS-1:0]     rdata_q;
  logic                  wr_set_lo, wr_clr_lo, wr_set_hi, wr_clr_hi;

  // reset: asserted at once, released after RST_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[RST_STAGES-1];

  // write decode
  always_comb begin
    wr_set_lo = bus_we && (bus_addr == A_MLO_SET);
    wr_clr_lo = bus_we && (bus_addr == A_MLO_CLR);
    wr_set_hi = bus_we && (bus_addr == A_MHI_SET);
    wr_clr_hi = bus_we && (bus_addr == A_MHI_CLR);
  end

  dpg_mode_bank #(.N_PINS(N_PINS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .set_lo  (wr_set_lo),
    .clr_lo  (wr_clr_lo),
    .set_hi  (wr_set_hi),
    .clr_hi  (wr_clr_hi),
    .mask    (bus_wdata),
    .mode_lo (mode_lo),
    .mode_hi (mode_hi)
  );

  dpg_pad_mux #(.N_PINS(N_PINS), .N_DUAL(N_DUAL)) u_mux (
    .mode_lo (mode_lo),
    .mode_hi (mode_hi),
    .per_out (per_out),
    .per_oe  (per_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  dpg_in_sync #(.N_PINS(N_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in (pad_in),
    .sync_out (pin_lvl)
  );

  // read path
  always_comb begin
    rdata_d = rdata_q;
    if (bus_re) begin
      unique case (bus_addr)
        A_PINLVL: rdata_d = pin_lvl;
        A_MLO:    rdata_d = mode_lo;
        A_MHI:    rdata_d = mode_hi;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rdata_q <= '0;
    end else if (bus_re) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/dpg_ctrl_chk.sv
module dpg_ctrl_chk
  import dpg_pkg::*;
#(
  parameter int unsigned N_PINS = 12,
  parameter int unsigned N_DUAL = 8
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic [N_PINS-1:0] bus_wdata,
  input logic [N_PINS-1:0] mode_lo,
  input logic [N_PINS-1:0] mode_hi,
  input logic [N_DUAL-1:0] per_out,
  input logic [N_DUAL-1:0] per_oe,
  input logic [N_PINS-1:0] pad_out,
  input logic [N_PINS-1:0] pad_oe,
  input logic [N_PINS-1:0] pad_in,
  input logic [N_PINS-1:0] pin_lvl
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic mode_write;
  assign mode_write = bus_we && (bus_addr == A_MLO_SET || bus_addr == A_MLO_CLR ||
                                 bus_addr == A_MHI_SET || bus_addr == A_MHI_CLR);

  assert_set_lo_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_we && bus_addr == A_MLO_SET) |=> mode_lo == ($past(mode_lo) | $past(bus_wdata)));

  assert_set_hi_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_we && bus_addr == A_MHI_SET) |=> mode_hi == ($past(mode_hi) | $past(bus_wdata)));

  assert_clr_lo_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_we && bus_addr == A_MLO_CLR) |=> mode_lo == ($past(mode_lo) & ~$past(bus_wdata)));

  assert_clr_hi_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_we && bus_addr == A_MHI_CLR) |=> mode_hi == ($past(mode_hi) & ~$past(bus_wdata)));

  assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    !mode_write |=> ($stable(mode_lo) && $stable(mode_hi)));

  assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (age_q >= 2'd2) |-> pin_lvl == $past(pad_in, 2));

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assert_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
      (!mode_hi[i] && !mode_lo[i]) |-> (!pad_oe[i] && !pad_out[i]));
    assert_drive_low_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
      (!mode_hi[i] && mode_lo[i]) |-> (pad_oe[i] && !pad_out[i]));
    assert_drive_high_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
      (mode_hi[i] && !mode_lo[i]) |-> (pad_oe[i] && pad_out[i]));
    if (i < N_DUAL) begin : g_dual
      assert_func_pass_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
        (mode_hi[i] && mode_lo[i]) |-> (pad_oe[i] == per_oe[i] && pad_out[i] == per_out[i]));
    end else begin : g_gpio
      assert_gpio_func_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
        (mode_hi[i] && mode_lo[i]) |-> (!pad_oe[i] && !pad_out[i]));
    end
  end

endmodule

bind dpg_ctrl dpg_ctrl_chk #(.N_PINS(N_PINS), .N_DUAL(N_DUAL)) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .mode_lo   (mode_lo),
  .mode_hi   (mode_hi),
  .per_out   (per_out),
  .per_oe    (per_oe),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_in    (pad_in),
  .pin_lvl   (pin_lvl)
);

// File: tb/dpg_ctrl_tb.sv
`timescale 1ns/1ps
module dpg_ctrl_tb;
  import dpg_pkg::*;

  localparam int unsigned NP = 12;
  localparam int unsigned ND = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              bus_we, bus_re;
  logic [REG_AW-1:0] bus_addr;
  logic [NP-1:0]     bus_wdata, bus_rdata;
  logic [ND-1:0]     per_out, per_oe;
  logic [NP-1:0]     pad_out, pad_oe, pad_in;

  dpg_ctrl #(.N_PINS(NP), .N_DUAL(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .per_out(per_out), .per_oe(per_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_in(pad_in)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [NP-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_seen = 1'b0;

  logic [NP-1:0] m_lo = '0;
  logic [NP-1:0] m_hi = '0;

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data against queued expectations
  always @(posedge clk) rd_seen <= bus_re;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_read(input logic [REG_AW-1:0] a, input logic [NP-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic bus_write(input logic [REG_AW-1:0] a, input logic [NP-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      A_MLO_SET: m_lo = m_lo | d;
      A_MLO_CLR: m_lo = m_lo & ~d;
      A_MHI_SET: m_hi = m_hi | d;
      A_MHI_CLR: m_hi = m_hi & ~d;
      default: ;
    endcase
  endtask

  task automatic check_pads(input string tag);
    logic [NP-1:0] e_oe, e_out;
    for (int i = 0; i < NP; i++) begin
      case ({m_hi[i], m_lo[i]})
        2'b01: begin e_oe[i] = 1'b1; e_out[i] = 1'b0; end
        2'b10: begin e_oe[i] = 1'b1; e_out[i] = 1'b1; end
        2'b11: begin
          if (i < ND) begin e_oe[i] = per_oe[i]; e_out[i] = per_out[i]; end
          else begin e_oe[i] = 1'b0; e_out[i] = 1'b0; end
        end
        default: begin e_oe[i] = 1'b0; e_out[i] = 1'b0; end
      endcase
    end
    #1;
    check({tag, " pad_oe"}, pad_oe, e_oe);
    check({tag, " pad_out"}, pad_out, e_out);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] held;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    per_out = '0; per_oe = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_pads("R1 reset");
    bus_read(A_MLO, '0, "R1 low plane after reset");
    bus_read(A_MHI, '0, "R1 high plane after reset");

    // R3 set, R2 readback
    bus_write(A_MLO_SET, 12'h0F3);
    bus_read(A_MLO, 12'h0F3, "R3 set low plane");
    bus_write(A_MLO_SET, 12'h100);
    bus_read(A_MLO, 12'h1F3, "R3 zero bits untouched by set");
    // R4 clear
    bus_write(A_MLO_CLR, 12'h003);
    bus_read(A_MLO, 12'h1F0, "R4 clear low plane");
    bus_write(A_MHI_SET, 12'h0F0);
    bus_read(A_MHI, 12'h0F0, "R2 high plane readback");
    check_pads("R5 R6 mixed modes");

    // R6 functional passthrough under changing peripheral signals
    per_out = 8'hA5; per_oe = 8'h3C;
    check_pads("R6 functional pattern A");
    per_out = 8'h5A; per_oe = 8'hC3;
    check_pads("R6 functional pattern B");

    // R5 drive high on pins 0 and 1
    bus_write(A_MHI_SET, 12'h003);
    check_pads("R5 drive high");

    // R7 GPIO-only pins in code 11
    bus_write(A_MLO_SET, 12'h600);
    bus_write(A_MHI_SET, 12'h600);
    per_out = 8'hFF; per_oe = 8'hFF;
    check_pads("R7 gpio-only code 11");
    bus_read(A_MLO, 12'h7F0, "R7 low plane keeps code 11");
    bus_read(A_MHI, 12'h6F3, "R7 high plane keeps code 11");

    // R4 on high plane: functional pins fall to drive low
    bus_write(A_MHI_CLR, 12'h0F0);
    bus_read(A_MHI, 12'h603, "R4 clear high plane");
    check_pads("R4 R5 functional to drive low");

    // R8 synchronizer latency
    pad_in = 12'hABC;
    bus_read(A_PINLVL, 12'h000, "R8 first edge old level");
    bus_read(A_PINLVL, 12'h000, "R8 second edge old level");
    bus_read(A_PINLVL, 12'hABC, "R8 third edge new level");

    // R9 pin levels whatever the mode
    pad_in = 12'h555;
    @(negedge clk); @(negedge clk);
    bus_read(A_PINLVL, 12'h555, "R9 levels on driven and functional pins");

    // R10 writes to read-only and unused words
    bus_write(A_PINLVL, '1);
    bus_write(A_MLO, '1);
    bus_write(A_MHI, '1);
    bus_write(3'd7, '1);
    bus_read(A_MLO, 12'h7F0, "R10 low plane unchanged");
    bus_read(A_MHI, 12'h603, "R10 high plane unchanged");
    check_pads("R10 pads unchanged");
    bus_read(3'd7, '0, "R10 unused word reads zero");
    bus_read(A_MLO_SET, '0, "R10 set word reads zero");

    // R11 read data holds while bus_re low
    bus_read(A_MLO, 12'h7F0, "R11 read before hold");
    held = 12'h7F0;
    bus_write(A_MLO_CLR, 12'hFFF);
    @(negedge clk);
    check("R11 rdata held", bus_rdata, held);
    bus_read(A_MLO, 12'h000, "R11 new read after clear");
    check_pads("R11 R5 pads after clear");

    @(negedge clk);
    check("R11 scoreboard drained", NP'(exp_q.size()), '0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule